// File: doc/BRIEF.md
# Outer-Product Tile Multiply-Accumulator

This block computes the product of a 3x4 operand tile A and a 4x5 operand tile B. The result is a 3x5 tile C. It does not form row-by-column dot products. Instead it builds C from four rank-1 updates. On each accepted step the caller presents one column of A and the matching row of B. Every row of C then takes a 5-lane vector multiply-accumulate, `C[i][j] += a[i] * b[j]`. One step therefore finishes with a single vector multiply and a single vector add per row, instead of five scalar operations of each kind.

A `start` pulse zeroes the accumulators and opens a run of four steps. Steps use a valid/ready handshake. After the fourth accepted step the block drops `vec_ready` and raises `done`. The finished tile stays on `tile_c` until the next `start`. A separate `clr` input zeroes the accumulators without changing the step count.

Top module: `outer_tile_mac`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it, `done` is 0, `vec_ready` is 0 and every element of `tile_c` is 0.
- R2: In the cycle after `start`, every element of `tile_c` is 0, `vec_ready` is 1, `done` is 0, and the step count restarts at zero.
- R3: A step is accepted only in a cycle where `vec_valid` and `vec_ready` are both 1 and `start` is 0. In a cycle with `vec_valid` 0, `tile_c` is unchanged.
- R4: An accepted step adds `a[i]*b[j]` to element (i,j) as signed values. `a[i]` is `col_a[16*i +: 16]`, `b[j]` is `row_b[16*j +: 16]`, and element (i,j) is `tile_c[40*(5*i+j) +: 40]`, all in two's complement. The result is visible in the next cycle.
- R5: In the cycle after the fourth accepted step, `done` is 1 and `vec_ready` is 0. Both stay that way until the next `start`.
- R6: A pair offered while `vec_ready` is 0 (after reset or after completion) leaves `tile_c` unchanged.
- R7: `clr` without an accepted step zeroes every element in the next cycle and does not change the step count.
- R8: `clr` in the same cycle as an accepted step makes each element equal to that step's product alone, and the step still counts.
- R9: `start` in the same cycle as an offered pair drops the pair: the tile is zero afterwards and four further steps are still needed.
- R10: Four steps with every operand at -32768 give 2^32 in every element, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new tile: clear accumulators, reset step count |
| clr | input | 1 | Zero the accumulators |
| vec_valid | input | 1 | Column/row pair is present |
| vec_ready | output | 1 | Block can accept a pair |
| col_a | input | 48 | Column of A, three signed 16-bit lanes |
| row_b | input | 80 | Row of B, five signed 16-bit lanes |
| done | output | 1 | Tile complete |
| tile_c | output | 600 | Result tile, fifteen signed 40-bit elements, row-major |

## Verification
Two functions can land in the same cycle: clearing the accumulators and accepting a step. The bench provokes this by raising `clr` together with a valid pair halfway through a tile. It expects each element to hold that step's product alone, and later steps to build on it. The step must also count toward completion, so `done` must appear after exactly two more steps. A second collision, `start` together with a valid pair, is judged by a zero tile and a full four further steps before `done`.

// File: rtl/outer_tile_mac.sv
module outer_tile_mac #(
  parameter int ROWS  = 3,
  parameter int DEPTH = 4,
  parameter int COLS  = 5,
  parameter int DW    = 16,
  parameter int AW    = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     clr,
  input  logic                     vec_valid,
  output logic                     vec_ready,
  input  logic [ROWS*DW-1:0]       col_a,
  input  logic [COLS*DW-1:0]       row_b,
  output logic                     done,
  output logic [ROWS*COLS*AW-1:0]  tile_c
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = 2 * DW;

  logic          busy;
  logic [CW-1:0] step;
  logic          take;

  assign take      = vec_valid && busy && !start;
  assign vec_ready = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      step <= '0;
    end else if (take) begin
      step <= step + 1'b1;
      if (step == CW'(DEPTH - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_lane
      logic signed [PW-1:0] prod;
      logic signed [AW-1:0] acc;

      assign prod = $signed(col_a[i*DW +: DW]) * $signed(row_b[j*DW +: DW]);
      assign tile_c[(i*COLS+j)*AW +: AW] = acc;

      always_ff @(posedge clk) begin
        if (!rst_n || start)
          acc <= '0;
        else if (take)
          acc <= (clr ? '0 : acc) + AW'(prod);
        else if (clr)
          acc <= '0;
      end
    end
  end
endmodule

// File: rtl/outer_tile_mac_chk.sv
module outer_tile_mac_chk #(
  parameter int ROWS  = 3,
  parameter int COLS  = 5,
  parameter int AW    = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    clr,
  input logic                    vec_valid,
  input logic                    vec_ready,
  input logic                    done,
  input logic [ROWS*COLS*AW-1:0] tile_c
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tile_c == '0) && vec_ready && !done);  // R2
  AST_NO_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && !start && !clr) |=> $stable(tile_c));  // R3
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vec_ready);  // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);  // R5
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_ready && !start && !clr) |=> $stable(tile_c));  // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start && !(vec_valid && vec_ready)) |=> (tile_c == '0));  // R7
endmodule

bind outer_tile_mac outer_tile_mac_chk #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .vec_valid(vec_valid),
  .vec_ready(vec_ready), .done(done), .tile_c(tile_c)
);

// File: tb/test_outer_tile_mac.sv
module test_outer_tile_mac;
  localparam int M = 3, N = 5, DW = 16, AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, clr = 1'b0, vec_valid = 1'b0;
  logic [M*DW-1:0] col_a = '0;
  logic [N*DW-1:0] row_b = '0;
  logic vec_ready, done;
  logic [M*N*AW-1:0] tile_c;

  always #5 clk = ~clk;

  outer_tile_mac i_outer_tile_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .col_a(col_a), .row_b(row_b), .done(done), .tile_c(tile_c)
  );

  int checks = 0, fails = 0;
  longint exp_c [M][N];
  bit exp_busy = 0, exp_done = 0;
  int exp_step = 0;

  // start, valid, clr, a0..a2, b0..b4
  localparam int TAB [14][11] = '{
    '{0,1,0, 1,2,3, 1,1,1,1,1},
    '{1,0,0, 0,0,0, 0,0,0,0,0},
    '{0,1,0, 1,-2,3, 4,5,-6,7,8},
    '{0,0,0, 9,9,9, 9,9,9,9,9},
    '{0,1,0, -7,0,2, 1,-1,2,-2,3},
    '{0,1,0, 100,-200,300, 10,20,30,40,50},
    '{0,1,0, -1000,5,6, 3,3,-3,-3,7},
    '{0,1,0, 5,5,5, 5,5,5,5,5},
    '{1,1,0, 2,2,2, 2,2,2,2,2},
    '{0,1,0, 3,1,4, 1,5,9,2,6},
    '{0,0,1, 0,0,0, 0,0,0,0,0},
    '{0,1,1, -3,7,11, 2,-4,6,-8,10},
    '{0,1,0, 1,1,1, 1,1,1,1,1},
    '{0,1,0, 30000,-30000,12345, -32768,32767,1,0,-1}
  };
  localparam string TAG [14] = '{"R6","R2","R4","R3","R4","R4","R5","R6",
                                 "R9","R4","R7","R8","R4","R5"};

  task automatic check(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++)
        check(req, longint'($signed(tile_c[(i*N+j)*AW +: AW])), exp_c[i][j],
              $sformatf("c[%0d][%0d]", i, j));
    check(req, longint'(done), longint'(exp_done), "done");
    check(req, longint'(vec_ready), longint'(exp_busy), "vec_ready");
  endtask

  task automatic cycle(input int row [11], input string req);
    start = row[0][0];
    vec_valid = row[1][0];
    clr = row[2][0];
    for (int i = 0; i < M; i++) col_a[i*DW +: DW] = row[3+i][DW-1:0];
    for (int j = 0; j < N; j++) row_b[j*DW +: DW] = row[6+j][DW-1:0];
    if (row[0] != 0) begin
      foreach (exp_c[i, j]) exp_c[i][j] = 0;
      exp_busy = 1; exp_done = 0; exp_step = 0;
    end else if (row[1] != 0 && exp_busy) begin
      foreach (exp_c[i, j])
        exp_c[i][j] = (row[2] != 0 ? 0 : exp_c[i][j]) + longint'(row[3+i]) * longint'(row[6+j]);
      exp_step++;
      if (exp_step == 4) begin exp_busy = 0; exp_done = 1; end
    end else if (row[2] != 0) begin
      foreach (exp_c[i, j]) exp_c[i][j] = 0;
    end
    @(negedge clk);
    start = 0; vec_valid = 0; clr = 0;
    check_all(req);
  endtask

  task automatic reset_model();
    foreach (exp_c[i, j]) exp_c[i][j] = 0;
    exp_busy = 0; exp_done = 0; exp_step = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int ext [11];
    reset_model();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    for (int t = 0; t < 14; t++) cycle(TAB[t], TAG[t]);

    ext = '{1,0,0, 0,0,0, 0,0,0,0,0};
    cycle(ext, "R2");
    ext = '{0,1,0, -32768,-32768,-32768, -32768,-32768,-32768,-32768,-32768};
    for (int s = 0; s < 4; s++) cycle(ext, "R10");
    check("R10", longint'($signed(tile_c[0 +: AW])), 64'sd4294967296, "c[0][0]");

    ext = '{1,0,0, 0,0,0, 0,0,0,0,0};
    cycle(ext, "R2");
    ext = '{0,1,0, 4,4,4, 4,4,4,4,4};
    cycle(ext, "R4");
    rst_n = 1'b0;
    reset_model();
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule